// File: doc/BRIEF.md
# Vectored Priority Interrupt Arbiter

This block decides which interrupt a small CPU core takes next and how it enters the service code. It receives a pending bit and an enable bit for each of sixteen arbitration ranks, a software trap request that cannot be masked, and an instruction-boundary strobe from the CPU sequencer. It also keeps the global interrupt enable register. A maskable source is active when both its bits are set. The block raises a request when the software trap is asked for, or when the global enable is set, at least one maskable source is active and no trap service is running.

At an instruction boundary with a request present, the block starts a fixed seven-cycle entry sequence. In the first cycle it tells the sequencer to replace the fetched opcode with opcode zero. In the second cycle it pushes the address of the instruction it displaced to the stack port. In the last cycle it loads the program counter with the dispatch address. The global enable is cleared as the sequence starts.

The block continuously records the winning rank and the address of that rank's two-byte vector table entry. The vector table sits at the top of a 256-byte page. The page is the one holding the vector-select routine, or the next page when that routine sits on the last byte of its page. Both values are frozen while the entry sequence runs, so that the vector-select routine reads a consistent result.

Top module: `vint_arbiter`

## Requirements
- R1: Bit i of `src_en_i` and `src_pend_i` belongs to rank i+1. Among active maskable sources, the lowest rank number wins. The maskable ranks are 3 to 7 and 9 to 15. A software trap request (`swtrap_i`) always wins as rank 1.
- R2: Bits 0, 1, 7 and 15 of the enable and pending inputs have no effect. When neither a trap nor an active maskable source exists, the selected rank is 16 (the default vector).
- R3: `vec_addr_o` equals {page, 8'hFE - 2*(rank-1)}. Rank 1 maps to low byte FE and rank 16 maps to E0.
- R4: The page is `vis_pc_i[15:8]`. It is incremented by one when `vis_pc_i[7:0]` is FF.
- R5: `irq_o` is registered. After each clock edge it shows (trap requested) OR (global enable AND no trap service in progress AND any maskable source active), evaluated on the inputs before that edge.
- R6: An entry starts only at a clock edge where `boundary_i` is 1, a request exists and no entry is running.
- R7: `busy_o` is high for exactly 7 cycles. `jam_o` pulses in the 1st cycle. `push_o` pulses in the 2nd cycle, with `ret_addr_o` equal to `pc_i` at the start. `pc_load_o` pulses in the 7th cycle, with `pc_target_o` = 16'h00FF.
- R8: The global enable is cleared when an entry starts. At other times it takes `gie_wdata_i` when `gie_wr_i` is 1.
- R9: Accepting a software trap sets `trap_act_o`. A `trap_ret_i` strobe clears it. While it is set, maskable sources raise no request even with the global enable at 1.
- R10: `sel_rank_o` and `vec_addr_o` update every cycle in which no entry is running, and hold their values for the whole entry sequence.
- R11: Reset sets the global enable, `irq_o`, `busy_o` and `trap_act_o` to 0 and `sel_rank_o` to 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_en_i | input | 16 | Per-rank enable bits, bit i = rank i+1 |
| src_pend_i | input | 16 | Per-rank pending bits, bit i = rank i+1 |
| swtrap_i | input | 1 | Software trap request |
| gie_wr_i | input | 1 | Global enable write strobe |
| gie_wdata_i | input | 1 | Global enable write value |
| boundary_i | input | 1 | Instruction boundary strobe |
| trap_ret_i | input | 1 | Return-from-trap strobe |
| pc_i | input | 16 | Address of the instruction about to run |
| vis_pc_i | input | 16 | Address of the vector-select routine |
| gie_o | output | 1 | Global interrupt enable |
| irq_o | output | 1 | Registered interrupt request |
| busy_o | output | 1 | Entry sequence in progress |
| jam_o | output | 1 | Replace the opcode with 00 |
| push_o | output | 1 | Push the return address |
| ret_addr_o | output | 16 | Return address to push |
| pc_load_o | output | 1 | Load the program counter |
| pc_target_o | output | 16 | Dispatch address |
| trap_act_o | output | 1 | Software trap service in progress |
| sel_rank_o | output | 5 | Winning rank, 1 to 16 |
| vec_addr_o | output | 16 | Vector table entry address |

## Verification
The in-RTL assertions check the following on every cycle:
- the global enable is low once an entry has started;
- no maskable entry starts during trap service or with the global enable off;
- the entry strobes never overlap, and busy stays high until the last entry cycle;
- the selected rank and vector stay frozen while busy.

The bench scenarios are needed for the behaviours that depend on the data:
- the rank order and the ignored reserved bits;
- the descending vector offsets and the page step at FF;
- the exact cycle position of each entry strobe and the pushed return address;
- the blocking and release of maskable requests around a trap.

// File: rtl/vint_pkg.sv
package vint_pkg;
  localparam int NRANK  = 16;
  localparam int IDX_W  = 4;
  localparam int RANK_W = 5;
  // bit i = rank i+1 ; ranks 1 (trap), 2, 8 (reserved) and 16 (default) are not maskable
  localparam logic [NRANK-1:0] MASKABLE = 16'h7F7C;

  function automatic logic [7:0] vec_off(input logic [IDX_W-1:0] idx);
    return 8'hFE - {3'b000, idx, 1'b0};
  endfunction

  function automatic logic [7:0] page_of(input logic [15:0] a);
    return a[15:8] + {7'd0, (a[7:0] == 8'hFF)};
  endfunction
endpackage

// File: rtl/vint_prio_enc.sv
module vint_prio_enc #(
  parameter int N = 16,
  parameter logic [N-1:0] MASK = '1,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  en_i,
  input  logic [N-1:0]  pend_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  logic [N-1:0] act;

  for (genvar i = 0; i < N; i++) begin : g_act
    if (MASK[i]) begin : g_live
      assign act[i] = en_i[i] & pend_i[i];
    end else begin : g_dead
      assign act[i] = 1'b0;
    end
  end

  always_comb begin
    idx_o = IW'(N - 1);
    for (int i = N - 1; i >= 0; i--) begin
      if (act[i]) idx_o = IW'(i);
    end
  end

  assign any_o = |act;
endmodule

// File: rtl/vint_entry_seq.sv
module vint_entry_seq #(
  parameter int CYC = 7,
  localparam int CW = (CYC > 1) ? $clog2(CYC) : 1,
  localparam logic [CW-1:0] LAST = CW'(CYC - 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o,
  output logic jam_o,
  output logic push_o,
  output logic load_o
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      cnt    <= '0;
    end else if (start_i && !busy_o) begin
      busy_o <= 1'b1;
      cnt    <= '0;
    end else if (busy_o) begin
      if (cnt == LAST) busy_o <= 1'b0;
      cnt <= cnt + 1'b1;
    end
  end

  assign jam_o  = busy_o && (cnt == '0);
  assign push_o = busy_o && (cnt == CW'(1));
  assign load_o = busy_o && (cnt == LAST);

  AST_ENTRY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !load_o) |=> busy_o); // R7
  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({jam_o, push_o, load_o})); // R7
  AST_START_JAM: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> jam_o); // R7
endmodule

// File: rtl/vint_arbiter.sv
module vint_arbiter
  import vint_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int ENTRY_CYC = 7,
  parameter logic [ADDR_W-1:0] DISPATCH = 16'h00FF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NRANK-1:0]     src_en_i,
  input  logic [NRANK-1:0]     src_pend_i,
  input  logic                 swtrap_i,
  input  logic                 gie_wr_i,
  input  logic                 gie_wdata_i,
  input  logic                 boundary_i,
  input  logic                 trap_ret_i,
  input  logic [ADDR_W-1:0]    pc_i,
  input  logic [ADDR_W-1:0]    vis_pc_i,
  output logic                 gie_o,
  output logic                 irq_o,
  output logic                 busy_o,
  output logic                 jam_o,
  output logic                 push_o,
  output logic [ADDR_W-1:0]    ret_addr_o,
  output logic                 pc_load_o,
  output logic [ADDR_W-1:0]    pc_target_o,
  output logic                 trap_act_o,
  output logic [RANK_W-1:0]    sel_rank_o,
  output logic [ADDR_W-1:0]    vec_addr_o
);
  logic             m_any;
  logic [IDX_W-1:0] m_idx;
  logic [IDX_W-1:0] win_idx;
  logic             req;
  logic             start;

  vint_prio_enc #(.N(NRANK), .MASK(MASKABLE)) u_enc (
    .en_i   (src_en_i),
    .pend_i (src_pend_i),
    .any_o  (m_any),
    .idx_o  (m_idx)
  );

  vint_entry_seq #(.CYC(ENTRY_CYC)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start_i (start),
    .busy_o  (busy_o),
    .jam_o   (jam_o),
    .push_o  (push_o),
    .load_o  (pc_load_o)
  );

  assign win_idx = swtrap_i ? '0 : m_idx;
  assign req     = swtrap_i | (gie_o & ~trap_act_o & m_any);
  assign start   = boundary_i & ~busy_o & req;
  assign pc_target_o = DISPATCH;

  always_ff @(posedge clk) begin
    if (rst) begin
      gie_o      <= 1'b0;
      irq_o      <= 1'b0;
      trap_act_o <= 1'b0;
      sel_rank_o <= RANK_W'(NRANK);
      vec_addr_o <= '0;
      ret_addr_o <= '0;
    end else begin
      irq_o <= req;
      if (start)         gie_o <= 1'b0;
      else if (gie_wr_i) gie_o <= gie_wdata_i;
      if (start && swtrap_i) trap_act_o <= 1'b1;
      else if (trap_ret_i)   trap_act_o <= 1'b0;
      if (!busy_o) begin
        sel_rank_o <= RANK_W'(win_idx) + RANK_W'(1);
        vec_addr_o <= {page_of(vis_pc_i), vec_off(win_idx)};
      end
      if (start) ret_addr_o <= pc_i;
    end
  end

  AST_GIE_CLEARED: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> !gie_o); // R8
  AST_NO_NEST: assert property (@(posedge clk) disable iff (rst)
    (start && trap_act_o) |-> swtrap_i); // R9
  AST_MASKED_NEEDS_GIE: assert property (@(posedge clk) disable iff (rst)
    (start && !swtrap_i) |-> gie_o); // R5
  AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> ($stable(sel_rank_o) && $stable(vec_addr_o))); // R10
  AST_RANK_RANGE: assert property (@(posedge clk) disable iff (rst)
    (sel_rank_o >= RANK_W'(1)) && (sel_rank_o <= RANK_W'(NRANK))); // R1
endmodule

// File: tb/vint_arbiter_tb.sv
`timescale 1ns/1ps
module vint_arbiter_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] src_en = '0, src_pend = '0, pc = '0, vis_pc = '0;
  logic        swtrap = 0, gie_wr = 0, gie_wd = 0, boundary = 0, trap_ret = 0;
  logic        gie_o, irq_o, busy_o, jam_o, push_o, pc_load_o, trap_act_o;
  logic [15:0] ret_addr_o, pc_target_o, vec_addr_o;
  logic [4:0]  sel_rank_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vint_arbiter u_dut (
    .clk(clk), .rst(rst), .src_en_i(src_en), .src_pend_i(src_pend),
    .swtrap_i(swtrap), .gie_wr_i(gie_wr), .gie_wdata_i(gie_wd),
    .boundary_i(boundary), .trap_ret_i(trap_ret), .pc_i(pc), .vis_pc_i(vis_pc),
    .gie_o(gie_o), .irq_o(irq_o), .busy_o(busy_o), .jam_o(jam_o), .push_o(push_o),
    .ret_addr_o(ret_addr_o), .pc_load_o(pc_load_o), .pc_target_o(pc_target_o),
    .trap_act_o(trap_act_o), .sel_rank_o(sel_rank_o), .vec_addr_o(vec_addr_o));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int ref_rank(input logic sw, input logic [15:0] en, input logic [15:0] pd);
    if (sw) return 1;
    for (int r = 3; r <= 15; r++)
      if (r != 8 && en[r-1] && pd[r-1]) return r;
    return 16;
  endfunction

  function automatic logic [15:0] ref_vec(input int rank, input logic [15:0] vpc);
    logic [7:0] pg;
    logic [7:0] off;
    pg = vpc[15:8];
    if (vpc[7:0] == 8'hFF) pg = pg + 8'd1;
    off = 8'(254 - 2 * (rank - 1));
    return {pg, off};
  endfunction

  task automatic apply(input logic g, input logic sw, input logic [15:0] en,
                       input logic [15:0] pd, input logic [15:0] vpc, input logic tr);
    int rk;
    @(negedge clk);
    gie_wr = 1; gie_wd = g; swtrap = sw; src_en = en; src_pend = pd; vis_pc = vpc; boundary = 0;
    @(negedge clk);
    gie_wr = 0;
    @(negedge clk);
    rk = ref_rank(sw, en, pd);
    check("R1 R2 sel_rank", 32'(sel_rank_o), 32'(rk));
    check("R3 R4 vec_addr", 32'(vec_addr_o), 32'(ref_vec(rk, vpc)));
    check("R5 R9 irq", 32'(irq_o), 32'(sw | (g & !tr & (rk != 16))));
  endtask

  // entry: pulse boundary, follow the 7-cycle sequence; change pending mid-way
  task automatic run_entry(input int exp_rank, input logic [15:0] pcv,
                           input logic [15:0] en2, input logic [15:0] pd2);
    int nb, jam_at, push_at, load_at;
    logic [15:0] pushed;
    nb = 0; jam_at = 0; push_at = 0; load_at = 0; pushed = '0;
    @(negedge clk);
    boundary = 1; pc = pcv;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      boundary = 0; swtrap = 0;
      if (i == 3) begin src_en = en2; src_pend = pd2; end
      if (busy_o) begin
        nb++;
        check("R10 sel frozen", 32'(sel_rank_o), 32'(exp_rank));
      end
      if (i == 1) check("R8 gie cleared", 32'(gie_o), 0);
      if (jam_o) jam_at = i;
      if (push_o) begin push_at = i; pushed = ret_addr_o; end
      if (pc_load_o) begin
        load_at = i;
        check("R7 pc target", 32'(pc_target_o), 32'h00FF);
      end
      if (i == 9) check("R10 sel resumes", 32'(sel_rank_o), 32'(ref_rank(0, en2, pd2)));
    end
    check("R7 busy length", 32'(nb), 7);
    check("R7 jam cycle", 32'(jam_at), 1);
    check("R7 push cycle", 32'(push_at), 2);
    check("R7 ret addr", 32'(pushed), 32'(pcv));
    check("R7 load cycle", 32'(load_at), 7);
  endtask

  // stimulus vectors: {gie, swtrap, en, pend, vis_pc}
  localparam logic [49:0] VEC [10] = '{
    {1'b1, 1'b0, 16'h0008, 16'h0008, 16'h1200},
    {1'b1, 1'b0, 16'hFFFF, 16'hFFFF, 16'h12FF},
    {1'b1, 1'b1, 16'hFFFF, 16'hFFFF, 16'h3440},
    {1'b1, 1'b0, 16'h8083, 16'h8083, 16'h0000},
    {1'b0, 1'b0, 16'h4000, 16'h4000, 16'hABFF},
    {1'b1, 1'b0, 16'h4000, 16'h0000, 16'h5510},
    {1'b1, 1'b0, 16'h0F00, 16'h0C00, 16'hFFFF},
    {1'b1, 1'b0, 16'h0104, 16'h0100, 16'h00FE},
    {1'b0, 1'b1, 16'h0000, 16'h0000, 16'h7701},
    {1'b1, 1'b0, 16'h0070, 16'h00F0, 16'h2222}
  };

  initial begin
    repeat (2) @(negedge clk);
    check("R11 gie reset", 32'(gie_o), 0);
    check("R11 irq reset", 32'(irq_o), 0);
    check("R11 busy reset", 32'(busy_o), 0);
    check("R11 trap reset", 32'(trap_act_o), 0);
    check("R11 rank reset", 32'(sel_rank_o), 16);
    rst = 0;

    for (int v = 0; v < 10; v++)
      apply(VEC[v][49], VEC[v][48], VEC[v][47:32], VEC[v][31:16], VEC[v][15:0], 1'b0);
    for (int k = 0; k < 40; k++)
      apply(1'($urandom), 1'($urandom_range(0, 7) == 0), 16'($urandom), 16'($urandom),
            16'($urandom), 1'b0);

    // R6: request present but no boundary -> no entry
    apply(1, 0, 16'h0008, 16'h0008, 16'h1200, 0);
    repeat (2) @(negedge clk);
    check("R6 no boundary no entry", 32'(busy_o), 0);
    // R6: boundary with global enable off -> no entry
    apply(0, 0, 16'h0008, 16'h0008, 16'h1200, 0);
    @(negedge clk); boundary = 1;
    @(negedge clk); boundary = 0;
    check("R6 gie off no entry", 32'(busy_o), 0);

    // R7 R8 R10: maskable entry on rank 4, rank 3 becomes pending mid-entry
    apply(1, 0, 16'h0008, 16'h0008, 16'h1200, 0);
    run_entry(4, 16'h1234, 16'h000C, 16'h000C);
    check("R8 gie stays low", 32'(gie_o), 0);

    // R9: software trap accepted, blocks maskable sources afterwards
    apply(0, 1, 16'h0000, 16'h0000, 16'h1200, 0);
    run_entry(1, 16'h0456, 16'h0000, 16'h0000);
    check("R9 trap flag set", 32'(trap_act_o), 1);
    apply(1, 0, 16'h0008, 16'h0008, 16'h1200, 1);
    @(negedge clk); boundary = 1;
    @(negedge clk); boundary = 0;
    check("R9 no nesting", 32'(busy_o), 0);
    @(negedge clk); trap_ret = 1;
    @(negedge clk); trap_ret = 0;
    check("R9 trap flag cleared", 32'(trap_act_o), 0);
    @(negedge clk);
    check("R9 irq after return", 32'(irq_o), 1);
    run_entry(4, 16'h0789, 16'h0008, 16'h0008);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule